// File: doc/BRIEF.md
# Per-CPU GPIO Interrupt Steering Unit

This unit sits beside the interrupt logic of a 32-line GPIO bank and lets up to four processors service that bank independently. Each processor has a private edge cause register and a private pair of edge and level mask registers. A global cause register and a global pair of masks remain available alongside them. The bank supplies its data-in vector, already corrected for polarity, and a one-cycle pulse for each line on which an edge was detected. Every pulse is latched into the global cause register and into each processor's cause register. Each copy is then cleared on its own.

The global registers are reached through the bank's main register port. The per-processor registers are reached through a second, separate register port. For each processor, and for the global set, a line is active when its data-in bit is high and its level mask bit is set, or when its cause bit is set and its edge mask bit is set. Every group of eight consecutive lines is OR-reduced into one summary interrupt output.

Top module: `gpio_cpu_irq_steer`

## Requirements
- R1: After reset, every cause and mask register (global and per-processor) reads as zero, and all interrupt outputs are low.
- R2: In the per-processor window, processor c (0 to 3) has its edge cause at byte offset 4*c, its edge mask at 0x10+4*c and its level mask at 0x20+4*c. A mask reads back the last value written to it.
- R3: An edge pulse on line i sets bit i in the global cause register and in the cause register of every processor, one clock after the pulse.
- R4: A write to any cause register clears the bits written as 0 and leaves the bits written as 1 unchanged. Only the addressed copy is affected.
- R5: When an edge pulse and a clearing write hit the same cause bit in the same cycle, the bit ends set.
- R6: Per-processor output bit c*4+g is high exactly when some line 8g..8g+7 has (data-in AND that processor's level mask) OR (that processor's cause AND its edge mask).
- R7: In the main window the global cause is at offset 0x14, the edge mask at 0x18 and the level mask at 0x1C. Global output bit g follows the rule of R6, using the global registers.
- R8: Any per-processor offset not named in R2, and any main-window offset not named in R7, reads as zero, and a write to such an offset changes no register.
- R9: Level-sensitive activity is not latched: an output driven only by data-in drops in the same cycle that data-in drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 32 | Polarity-corrected line levels |
| edge_evt | input | 32 | One-cycle edge detection pulses, one per line |
| g_we | input | 1 | Main window write strobe |
| g_addr | input | 5 | Main window byte offset |
| g_wdata | input | 32 | Main window write data |
| g_rdata | output | 32 | Main window read data (combinational) |
| c_we | input | 1 | Per-processor window write strobe |
| c_addr | input | 6 | Per-processor window byte offset |
| c_wdata | input | 32 | Per-processor window write data |
| c_rdata | output | 32 | Per-processor window read data (combinational) |
| g_irq | output | 4 | Global group interrupts, one per eight lines |
| c_irq | output | 16 | Per-processor group interrupts, bit c*4+g |

## Verification
If a cause copy is wrongly shared or wrongly cleared, the error shows up in the next read of a sibling cause register, because an edge on one line must be seen in all five copies while a write clears only one. A mask stored at the wrong offset shows up in the next readback, and it also raises the wrong group bit in the same cycle that its enable takes effect. Level activity involves no state, so a stale latch shows up as an output that stays high in the same cycle data-in falls.

// File: rtl/gpio_cpu_irq_steer.sv
module gpio_cpu_irq_steer #(
  parameter int NLINES = 32,
  parameter int NCPU   = 4,
  parameter int GRP    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINES-1:0]         data_in,
  input  logic [NLINES-1:0]         edge_evt,
  input  logic                      g_we,
  input  logic [4:0]                g_addr,
  input  logic [NLINES-1:0]         g_wdata,
  output logic [NLINES-1:0]         g_rdata,
  input  logic                      c_we,
  input  logic [5:0]                c_addr,
  input  logic [NLINES-1:0]         c_wdata,
  output logic [NLINES-1:0]         c_rdata,
  output logic [(NLINES+GRP-1)/GRP-1:0]      g_irq,
  output logic [NCPU*((NLINES+GRP-1)/GRP)-1:0] c_irq
);
  localparam int NGRP = (NLINES + GRP - 1) / GRP;
  localparam int PADW = NGRP * GRP;

  logic [NLINES-1:0] gcause, gem, glm;
  logic [NLINES-1:0] pcause [NCPU];
  logic [NLINES-1:0] pem    [NCPU];
  logic [NLINES-1:0] plm    [NCPU];

  wire g_hit_c = g_addr == 5'h14;
  wire g_hit_e = g_addr == 5'h18;
  wire g_hit_l = g_addr == 5'h1c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gcause <= '0;
      gem    <= '0;
      glm    <= '0;
    end else begin
      gcause <= ((g_we && g_hit_c) ? (gcause & g_wdata) : gcause) | edge_evt;
      if (g_we && g_hit_e) gem <= g_wdata;
      if (g_we && g_hit_l) glm <= g_wdata;
    end

  assign g_rdata = g_hit_c ? gcause : g_hit_e ? gem : g_hit_l ? glm : '0;

  wire [NLINES-1:0] g_act  = (data_in & glm) | (gcause & gem);
  wire [PADW-1:0]   g_actp = PADW'(g_act);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign g_irq[g] = |g_actp[g*GRP +: GRP];
  end

  logic [NLINES-1:0] rd_terms [NCPU];

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    wire hit_c = c_addr == 6'(4*c);
    wire hit_e = c_addr == 6'(16 + 4*c);
    wire hit_l = c_addr == 6'(32 + 4*c);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pcause[c] <= '0;
        pem[c]    <= '0;
        plm[c]    <= '0;
      end else begin
        pcause[c] <= ((c_we && hit_c) ? (pcause[c] & c_wdata) : pcause[c]) | edge_evt;
        if (c_we && hit_e) pem[c] <= c_wdata;
        if (c_we && hit_l) plm[c] <= c_wdata;
      end

    assign rd_terms[c] = ({NLINES{hit_c}} & pcause[c]) |
                         ({NLINES{hit_e}} & pem[c]) |
                         ({NLINES{hit_l}} & plm[c]);

    wire [NLINES-1:0] act  = (data_in & plm[c]) | (pcause[c] & pem[c]);
    wire [PADW-1:0]   actp = PADW'(act);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign c_irq[c*NGRP + g] = |actp[g*GRP +: GRP];
    end
  end

  always_comb begin
    c_rdata = '0;
    for (int c = 0; c < NCPU; c++) c_rdata = c_rdata | rd_terms[c];
  end
endmodule

module steer_chk #(
  parameter int NLINES = 32,
  parameter int NCPU   = 4,
  parameter int GRP    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NLINES-1:0]    edge_evt,
  input logic                 c_we,
  input logic [5:0]           c_addr,
  input logic [NLINES-1:0]    pcause [NCPU],
  input logic [NLINES-1:0]    pem    [NCPU],
  input logic [NLINES-1:0]    plm    [NCPU],
  input logic [NLINES-1:0]    gem,
  input logic [NLINES-1:0]    glm,
  input logic [(NLINES+GRP-1)/GRP-1:0]        g_irq,
  input logic [NCPU*((NLINES+GRP-1)/GRP)-1:0] c_irq
);
  localparam int NGRP = (NLINES + GRP - 1) / GRP;
  localparam int PADW = NGRP * GRP;

  wire [3:0] widx = c_addr[5:2];
  wire c_used = (c_addr[1:0] == 2'b00) && (widx < 4'd12) && (32'(widx[1:0]) < NCPU);

  wire [PADW-1:0] genp = PADW'(gem | glm);
  for (genvar g = 0; g < NGRP; g++) begin : g_gchk
    a_r7_gbl_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      g_irq[g] |-> |genp[g*GRP +: GRP]);
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    a_r3_evt_sets_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_evt) |=> ((pcause[c] & $past(edge_evt)) == $past(edge_evt)));

    a_r4_no_set_without_evt: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pcause[c] & ~$past(pcause[c]) & ~$past(edge_evt)) == '0));

    a_r8_unused_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (c_we && !c_used) |=> ($stable(pem[c]) && $stable(plm[c])));

    a_r8_unused_cause_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (c_we && !c_used && !(|edge_evt)) |=> $stable(pcause[c]));

    wire [PADW-1:0] enp = PADW'(pem[c] | plm[c]);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      a_r6_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        c_irq[c*NGRP + g] |-> |enp[g*GRP +: GRP]);
    end
  end
endmodule

bind gpio_cpu_irq_steer steer_chk #(.NLINES(NLINES), .NCPU(NCPU), .GRP(GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .c_we(c_we), .c_addr(c_addr),
  .pcause(pcause), .pem(pem), .plm(plm), .gem(gem), .glm(glm),
  .g_irq(g_irq), .c_irq(c_irq)
);

// File: tb/test_gpio_cpu_irq_steer.sv
`timescale 1ns/100ps
module test_gpio_cpu_irq_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data_in = '0, edge_evt = '0;
  logic        g_we = 1'b0, c_we = 1'b0;
  logic [4:0]  g_addr = '0;
  logic [5:0]  c_addr = '0;
  logic [31:0] g_wdata = '0, c_wdata = '0;
  logic [31:0] g_rdata, c_rdata;
  logic [3:0]  g_irq;
  logic [15:0] c_irq;

  always #2 clk = ~clk;

  gpio_cpu_irq_steer i_gpio_cpu_irq_steer (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .edge_evt(edge_evt),
    .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata), .g_rdata(g_rdata),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .g_irq(g_irq), .c_irq(c_irq)
  );

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int nchk = 0, nerr = 0;
  bit done = 0;

  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = c_rdata;
        1: act = g_rdata;
        2: act = {16'h0, c_irq};
        default: act = {28'h0, g_irq};
      endcase
      nchk++;
      if (act !== it.exp) begin
        nerr++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int sel, logic [31:0] e, string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    #0.5 q.push_back(it);
    #1;
  endtask

  task automatic exp_c(logic [5:0] a, logic [31:0] e, string tag);
    @(negedge clk); c_addr = a; push(0, e, tag);
  endtask
  task automatic exp_g(logic [4:0] a, logic [31:0] e, string tag);
    @(negedge clk); g_addr = a; push(1, e, tag);
  endtask
  task automatic exp_ci(logic [15:0] e, string tag);
    @(negedge clk); push(2, {16'h0, e}, tag);
  endtask
  task automatic exp_gi(logic [3:0] e, string tag);
    @(negedge clk); push(3, {28'h0, e}, tag);
  endtask

  task automatic wr_c(logic [5:0] a, logic [31:0] d, logic [31:0] ev);
    @(negedge clk); c_we = 1; c_addr = a; c_wdata = d; edge_evt = ev;
    @(negedge clk); c_we = 0; edge_evt = '0;
  endtask
  task automatic wr_g(logic [4:0] a, logic [31:0] d);
    @(negedge clk); g_we = 1; g_addr = a; g_wdata = d;
    @(negedge clk); g_we = 0;
  endtask
  task automatic pulse(logic [31:0] ev);
    @(negedge clk); edge_evt = ev;
    @(negedge clk); edge_evt = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      exp_c(6'(4*c), 0, "R1 cause");
      exp_c(6'(16+4*c), 0, "R1 emask");
      exp_c(6'(32+4*c), 0, "R1 lmask");
    end
    exp_g(5'h14, 0, "R1 gcause");
    exp_g(5'h18, 0, "R1 gemask");
    exp_ci(0, "R1 c_irq");
    exp_gi(0, "R1 g_irq");

    // R2 mask offsets and readback
    for (int c = 0; c < 4; c++) begin
      wr_c(6'(16+4*c), 32'hA5A5_0000 ^ 32'(c), 0);
      wr_c(6'(32+4*c), 32'h0000_5A5A + 32'(c), 0);
    end
    for (int c = 0; c < 4; c++) begin
      exp_c(6'(16+4*c), 32'hA5A5_0000 ^ 32'(c), "R2 emask");
      exp_c(6'(32+4*c), 32'h0000_5A5A + 32'(c), "R2 lmask");
    end
    for (int c = 0; c < 4; c++) begin
      wr_c(6'(16+4*c), 0, 0);
      wr_c(6'(32+4*c), 0, 0);
    end

    // R8 unused offsets
    wr_c(6'h30, 32'hFFFF_FFFF, 0);
    wr_c(6'h02, 32'hFFFF_FFFF, 0);
    wr_g(5'h00, 32'hFFFF_FFFF);
    exp_c(6'h30, 0, "R8 read unused 0x30");
    exp_c(6'h02, 0, "R8 read unused 0x02");
    exp_c(6'h10, 0, "R8 emask untouched");
    exp_c(6'h20, 0, "R8 lmask untouched");
    exp_g(5'h00, 0, "R8 main unused");
    exp_g(5'h18, 0, "R8 gemask untouched");

    // R3 event fan-out
    pulse(32'h0000_0081);
    for (int c = 0; c < 4; c++) exp_c(6'(4*c), 32'h81, "R3 cause copy");
    exp_g(5'h14, 32'h81, "R3 gcause");

    // R4 write-zero-to-clear, independent copies
    wr_c(6'h04, ~32'h1, 0);
    exp_c(6'h04, 32'h80, "R4 cpu1 cleared bit0");
    exp_c(6'h00, 32'h81, "R4 cpu0 intact");
    exp_g(5'h14, 32'h81, "R4 gcause intact");
    wr_c(6'h04, 32'hFFFF_FFFF, 0);
    exp_c(6'h04, 32'h80, "R4 ones keep");

    // R5 set wins over clear
    wr_c(6'h08, 0, 32'h1);
    exp_c(6'h08, 32'h1, "R5 set wins");

    // R6 per-processor edge path
    wr_c(6'h10, 32'h80, 0);
    exp_ci(16'h0001, "R6 cpu0 edge");
    wr_c(6'h1c, 32'h1, 0);
    exp_ci(16'h1001, "R6 cpu3 edge");

    // R6/R9 level path
    wr_c(6'h24, 32'h0000_FF00, 0);
    @(negedge clk); data_in = 32'h0000_0400;
    exp_ci(16'h1021, "R6 cpu1 level");
    @(negedge clk); data_in = 32'h0;
    push(2, 32'h1001, "R9 level drops at once");
    @(negedge clk); data_in = 32'h00FF_0000;
    exp_ci(16'h1001, "R6 unmasked level ignored");

    // R7 global window
    wr_g(5'h18, 32'h1);
    exp_gi(4'h1, "R7 global edge");
    wr_g(5'h1c, 32'hFF00_0000);
    @(negedge clk); data_in = 32'h8000_0000;
    exp_gi(4'h9, "R7 global level");
    exp_g(5'h18, 32'h1, "R7 gemask readback");
    exp_g(5'h1c, 32'hFF00_0000, "R7 glmask readback");
    wr_g(5'h14, 32'h0);
    exp_g(5'h14, 32'h0, "R7 gcause cleared");
    exp_gi(4'h8, "R7 global edge gone");
    exp_c(6'h00, 32'h81, "R4 cpu0 unaffected by global clear");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule